// File: doc/BRIEF.md
# GPIO Controller with Edge-Detect Interrupts

A register-mapped general-purpose I/O block for 28 pins. Software reaches it over a simple 32-bit bus: an address, a write strobe, write data and a read-data return. Each pin has an output latch, a direction bit that drives an output-enable mask, and an alternate-function bit that is only exported as a mask for the pin multiplexers. The output latch has no read-modify-write path. It is changed through two write-only registers, one that raises bits and one that lowers them.

Pin inputs are brought into the clock domain by a two-flop synchronizer. The synchronized level can be read back at any time. Two per-pin enables, one for rising and one for falling transitions, decide which transitions set a sticky status bit. Software clears a status bit by writing a 1 to it. Twelve interrupt lines leave the block. Pins 0 to 10 each own one line. The status of pins 11 to 27 is combined onto the twelfth line.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset every register is zero: every read returns 0, and `pins_o`, `oe_o`, `alt_o` and `irq_o` are all 0.
- R2: The register offsets are: 0x00 pin level (read-only), 0x04 direction, 0x08 output set (write-only), 0x0C output clear (write-only), 0x10 rising enable, 0x14 falling enable, 0x18 edge status, 0x1C alternate function. Bit n belongs to pin n. Bits 31:28 read as 0. The set and clear offsets read as 0, and writes to the level offset have no effect.
- R3: Writing to the set register drives the output latch bit of each pin written with a 1 to 1. Bits written as 0 keep their value.
- R4: Writing to the clear register drives the output latch bit of each pin written with a 1 to 0. Bits written as 0 keep their value.
- R5: `oe_o` follows the direction register (1 = output, 0 = input). `alt_o` follows the alternate-function register (1 = alternate function, 0 = GPIO).
- R6: The level register returns each pin's input after two clock edges of synchronization, whatever the pin's direction.
- R7: A 0-to-1 transition of a pin's synchronized level sets its status bit when its rising enable is 1. A 1-to-0 transition sets it when its falling enable is 1. With both enables set, either transition sets it. With both clear, neither does. The bit is set on the third clock edge after the pin changes.
- R8: Writing a 1 to a status bit clears it. Bits written as 0, including an all-zero write, stay as they are.
- R9: When a new edge and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R10: `irq_o[n]` for n in 0..10 equals status bit n. `irq_o[11]` is the OR of status bits 11 to 27.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register byte address |
| we_i | input | 1 | Write strobe for the current cycle |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| pins_i | input | 28 | Pin input levels (asynchronous) |
| pins_o | output | 28 | Output latch |
| oe_o | output | 28 | Output enable per pin |
| alt_o | output | 28 | Alternate-function select mask |
| irq_o | output | 12 | Interrupt lines: 0..10 dedicated, 11 shared |

## Verification
The bench aims a clearing write at the exact cycle in which a new edge lands on a status bit that is already set. A design that lets the clear win loses that interrupt. An all-zero write to the status register is checked to clear nothing, which catches a decoder that treats any write as a full clear. Transitions are driven against the wrong enable and with no enable at all, which catches swapped rising and falling masks. A pin above 10 is checked to raise only the shared line, which catches an off-by-one in the dedicated and shared split. Register reads confirm that the unused top bits and the write-only offsets return zero.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  parameter int ADDR_W = 8;

  parameter logic [ADDR_W-1:0] OFS_LEVEL = 8'h00;
  parameter logic [ADDR_W-1:0] OFS_DIR   = 8'h04;
  parameter logic [ADDR_W-1:0] OFS_SET   = 8'h08;
  parameter logic [ADDR_W-1:0] OFS_CLR   = 8'h0C;
  parameter logic [ADDR_W-1:0] OFS_RISE  = 8'h10;
  parameter logic [ADDR_W-1:0] OFS_FALL  = 8'h14;
  parameter logic [ADDR_W-1:0] OFS_EDGE  = 8'h18;
  parameter logic [ADDR_W-1:0] OFS_ALT   = 8'h1C;

  typedef enum logic [3:0] {
    SEL_LEVEL, SEL_DIR, SEL_SET, SEL_CLR,
    SEL_RISE, SEL_FALL, SEL_EDGE, SEL_ALT, SEL_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
    case (a)
      OFS_LEVEL: return SEL_LEVEL;
      OFS_DIR:   return SEL_DIR;
      OFS_SET:   return SEL_SET;
      OFS_CLR:   return SEL_CLR;
      OFS_RISE:  return SEL_RISE;
      OFS_FALL:  return SEL_FALL;
      OFS_EDGE:  return SEL_EDGE;
      OFS_ALT:   return SEL_ALT;
      default:   return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 28
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
  parameter int W = 28
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] rise_en_i,
  input  logic [W-1:0] fall_en_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] status_o
);
  logic [W-1:0] prev_q, status_q, evt;

  assign evt = (sync_i & ~prev_q & rise_en_i) | (~sync_i & prev_q & fall_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= sync_i;
      status_q <= (status_q & ~clr_i) | evt;  // edge overrides clear
    end
  end

  assign status_o = status_q;

  // R8
  w1c_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & ~evt)) |=> ((status_q & $past(clr_i & ~evt)) == '0));

  // R9
  edge_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt) |=> ((status_q & $past(evt)) == $past(evt)));

  // R7
  no_spurious_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_q & ~$past(status_q) & ~$past(evt)) == '0));
endmodule

// File: rtl/gpio_irq_map.sv
module gpio_irq_map #(
  parameter int W    = 28,
  parameter int NDED = 11
) (
  input  logic [W-1:0] status_i,
  output logic [NDED:0] irq_o
);
  localparam int NSHR = W - NDED;

  for (genvar i = 0; i < NDED; i++) begin : g_ded
    assign irq_o[i] = status_i[i];
  end

  logic [NSHR-1:0] shared;
  assign shared      = status_i[W-1:NDED];
  assign irq_o[NDED] = |shared;
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int NPINS = 28,
  parameter int NDED  = 11,
  parameter int DW    = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [NPINS-1:0]  pins_i,
  output logic [NPINS-1:0]  pins_o,
  output logic [NPINS-1:0]  oe_o,
  output logic [NPINS-1:0]  alt_o,
  output logic [NDED:0]     irq_o
);
  localparam int PAD = DW - NPINS;

  reg_sel_e         sel;
  logic [NPINS-1:0] wd, level, status, clr;
  logic [NPINS-1:0] dir_q, alt_q, rise_q, fall_q, out_q;
  logic [NPINS-1:0] rd;

  assign sel = decode(addr_i);
  assign wd  = wdata_i[NPINS-1:0];
  assign clr = (we_i && sel == SEL_EDGE) ? wd : '0;

  gpio_sync #(.W(NPINS)) u_sync (
    .clk_i, .rst_ni, .async_i(pins_i), .sync_o(level)
  );

  gpio_edge_det #(.W(NPINS)) u_edge (
    .clk_i, .rst_ni, .sync_i(level), .rise_en_i(rise_q), .fall_en_i(fall_q),
    .clr_i(clr), .status_o(status)
  );

  gpio_irq_map #(.W(NPINS), .NDED(NDED)) u_irq (
    .status_i(status), .irq_o(irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      alt_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      out_q  <= '0;
    end else if (we_i) begin
      case (sel)
        SEL_DIR:  dir_q  <= wd;
        SEL_ALT:  alt_q  <= wd;
        SEL_RISE: rise_q <= wd;
        SEL_FALL: fall_q <= wd;
        SEL_SET:  out_q  <= out_q | wd;
        SEL_CLR:  out_q  <= out_q & ~wd;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_LEVEL: rd = level;
      SEL_DIR:   rd = dir_q;
      SEL_RISE:  rd = rise_q;
      SEL_FALL:  rd = fall_q;
      SEL_EDGE:  rd = status;
      SEL_ALT:   rd = alt_q;
      default:   rd = '0;
    endcase
  end

  assign rdata_o = {{PAD{1'b0}}, rd};
  assign pins_o  = out_q;
  assign oe_o    = dir_q;
  assign alt_o   = alt_q;

  // R3
  set_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel == SEL_SET) |=> ((pins_o & $past(wd)) == $past(wd)));

  // R4
  clr_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel == SEL_CLR) |=> ((pins_o & $past(wd)) == '0));

  // R3
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && (sel == SEL_SET || sel == SEL_CLR)) |=> $stable(pins_o));
endmodule

// File: tb/sim_gpio_edge_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_edge_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [27:0] pins_in = '0;
  logic [27:0] pins_out, oe, alt;
  logic [11:0] irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  gpio_edge_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pins_i(pins_in), .pins_o(pins_out), .oe_o(oe),
    .alt_o(alt), .irq_o(irq)
  );

  localparam logic [7:0] A_LVL = 8'h00, A_DIR = 8'h04, A_SET = 8'h08, A_CLR = 8'h0C,
                         A_RISE = 8'h10, A_FALL = 8'h14, A_EDGE = 8'h18, A_ALT = 8'h1C;

  // {addr, write data, expected read-back}
  localparam int NV = 8;
  localparam logic [71:0] VECS [NV] = '{
    {A_DIR,  32'hFFFF_FFFF, 32'h0FFF_FFFF},
    {A_DIR,  32'h1234_5678, 32'h0234_5678},
    {A_RISE, 32'hF0F0_F0F0, 32'h00F0_F0F0},
    {A_FALL, 32'h0F0F_0F0F, 32'h0F0F_0F0F},
    {A_ALT,  32'hDEAD_BEEF, 32'h0EAD_BEEF},
    {A_SET,  32'h0000_0000, 32'h0000_0000},
    {A_CLR,  32'h0000_0000, 32'h0000_0000},
    {A_LVL,  32'hFFFF_FFFF, 32'h0000_0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // caller sits at a negedge
  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus_rd(a, v);
    chk(tag, v, exp);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);

    // R1 reset state
    for (int a = 0; a < 8; a++) rd_chk("R1 reset read", 8'(a * 4), 32'h0);
    chk("R1 pins_o", {4'h0, pins_out}, 32'h0);
    chk("R1 oe_o", {4'h0, oe}, 32'h0);
    chk("R1 alt_o", {4'h0, alt}, 32'h0);
    chk("R1 irq_o", {20'h0, irq}, 32'h0);

    // R6 level readback, input direction then output direction
    pins_in = 28'hABC_DEF1;
    wait_n(3);
    rd_chk("R6 level dir=in", A_LVL, 32'h0ABC_DEF1);
    bus_wr(A_DIR, 32'h0FFF_FFFF);
    rd_chk("R6 level dir=out", A_LVL, 32'h0ABC_DEF1);
    pins_in = '0;
    wait_n(4);
    rd_chk("R6 level low", A_LVL, 32'h0);

    // R2 register map via vector table
    for (int i = 0; i < NV; i++) begin
      bus_wr(VECS[i][71:64], VECS[i][63:32]);
      rd_chk("R2 map", VECS[i][71:64], VECS[i][31:0]);
    end
    chk("R5 oe_o", {4'h0, oe}, 32'h0234_5678);
    chk("R5 alt_o", {4'h0, alt}, 32'h0EAD_BEEF);
    chk("R2 level write ignored", {4'h0, pins_out}, 32'h0);

    // R3 / R4 output latch
    bus_wr(A_SET, 32'h0000_00F0);
    chk("R3 set", {4'h0, pins_out}, 32'h0000_00F0);
    bus_wr(A_SET, 32'h0800_0001);
    chk("R3 set accumulates", {4'h0, pins_out}, 32'h0800_00F1);
    bus_wr(A_CLR, 32'h0000_0030);
    chk("R4 clear", {4'h0, pins_out}, 32'h0800_00C1);
    bus_wr(A_CLR, 32'h0);
    chk("R4 zero clear", {4'h0, pins_out}, 32'h0800_00C1);

    // edge setup: rise on 3 and 5, fall on 20 and 5, pin 7 none
    bus_wr(A_RISE, 32'h0000_0028);
    bus_wr(A_FALL, 32'h0010_0020);
    bus_wr(A_EDGE, 32'h0FFF_FFFF);
    rd_chk("R8 initial clear", A_EDGE, 32'h0);

    // R7 rising on pin 3, R10 dedicated line
    pins_in[3] = 1'b1;
    wait_n(4);
    rd_chk("R7 rise pin3", A_EDGE, 32'h0000_0008);
    chk("R10 irq pin3", {20'h0, irq}, 32'h0000_0008);
    pins_in[3] = 1'b0;
    wait_n(4);
    rd_chk("R7 fall not enabled pin3", A_EDGE, 32'h0000_0008);

    // R8 write-one-to-clear
    bus_wr(A_EDGE, 32'h0);
    rd_chk("R8 zero write keeps", A_EDGE, 32'h0000_0008);
    bus_wr(A_EDGE, 32'h0000_0008);
    rd_chk("R8 one write clears", A_EDGE, 32'h0);
    chk("R8 irq cleared", {20'h0, irq}, 32'h0);

    // R7 no enables on pin 7
    pins_in[7] = 1'b1;
    wait_n(4);
    pins_in[7] = 1'b0;
    wait_n(4);
    rd_chk("R7 no enable pin7", A_EDGE, 32'h0);

    // R7 / R10 shared line on pin 20 (falling only)
    pins_in[20] = 1'b1;
    wait_n(4);
    rd_chk("R7 rise not enabled pin20", A_EDGE, 32'h0);
    pins_in[20] = 1'b0;
    wait_n(4);
    rd_chk("R7 fall pin20", A_EDGE, 32'h0010_0000);
    chk("R10 shared irq", {20'h0, irq}, 32'h0000_0800);
    bus_wr(A_EDGE, 32'h0010_0000);

    // R7 both enables on pin 5
    pins_in[5] = 1'b1;
    wait_n(4);
    rd_chk("R7 both rise pin5", A_EDGE, 32'h0000_0020);
    bus_wr(A_EDGE, 32'h0000_0020);
    pins_in[5] = 1'b0;
    wait_n(4);
    rd_chk("R7 both fall pin5", A_EDGE, 32'h0000_0020);
    chk("R10 irq pin5", {20'h0, irq}, 32'h0000_0020);

    // R9 clear lands in the same cycle as a new edge (third edge after change)
    pins_in[5] = 1'b1;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    bus_wr(A_EDGE, 32'h0000_0020);
    rd_chk("R9 edge beats clear", A_EDGE, 32'h0000_0020);
    bus_wr(A_EDGE, 32'h0000_0020);
    rd_chk("R8 clear after collision", A_EDGE, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule